// File: doc/BRIEF.md
# Loop-Capture Mode Controller

This controller decides when an issue queue should start holding on to the instructions of a small loop and when the pipeline front end may be switched off. It watches the control-transfer instructions leaving decode, each with its predicted target. It also sees a loop-body size estimate, the queue capacity, misprediction notices and three abort events: an inner loop was seen, the loop was left, or the queue ran full. From these it moves between three modes: `MODE_NORMAL`, `MODE_BUFFER` and `MODE_REUSE`.

A backward conditional branch or direct jump whose body fits in the queue marks the end of a loop's first pass. When that branch is seen, the controller moves from `MODE_NORMAL` to `MODE_BUFFER`, so buffering covers the second and later iterations. Each time the same loop-end branch decodes again, one more whole iteration has been buffered. When the queue could not hold one more iteration, the controller moves to `MODE_REUSE` and gates the front end. A misprediction in `MODE_REUSE` returns it to `MODE_NORMAL`; this includes the one raised on normal loop exit. An abort event in `MODE_BUFFER` revokes buffering and writes the loop-end PC into a small table of loops that must not be captured again. A misprediction in `MODE_BUFFER` revokes buffering without writing to that table.

The transitions are: capture (`MODE_NORMAL`→`MODE_BUFFER`), abort (`MODE_BUFFER`→`MODE_NORMAL`, recorded), cancel (`MODE_BUFFER`→`MODE_NORMAL` on misprediction, not recorded), commit (`MODE_BUFFER`→`MODE_REUSE`) and restore (`MODE_REUSE`→`MODE_NORMAL`). Every other case holds the current mode.

Top module: `loop_capture_ctrl`

## Requirements
- R1: A capture happens only for a decoded transfer with `dec_valid`=1, `dec_kind` 2'b01 (conditional) or 2'b10 (direct jump), `dec_target` < `dec_pc` and 0 < `body_size` <= `iq_capacity`. Such a transfer in `MODE_NORMAL` whose PC misses the table raises `buffer_en` after the next clock edge. Kinds 2'b00 and 2'b11, forward targets and oversize bodies leave the mode at `MODE_NORMAL`.
- R2: `buffer_en` is high exactly while in `MODE_BUFFER`, and `fe_gate` is never high outside `MODE_REUSE`.
- R3: In `MODE_BUFFER`, any of `evt_inner_loop`, `evt_loop_exit` or `evt_queue_full` returns the mode to `MODE_NORMAL` and raises `revoke_pulse` for exactly one cycle. It also records the buffered loop's end PC in the table.
- R4: A candidate whose PC hits the table starts no buffering.
- R5: The table has 8 entries, is filled and replaced in round-robin order, and never holds the same PC twice. The ninth recording evicts the first, which makes that loop capturable again.
- R6: The loop-end branch (same PC, kind 2'b01 or 2'b10) adds one latched body size to the buffered count each time it decodes in `MODE_BUFFER`. The controller commits to `MODE_REUSE` on the first such decode after which the count plus one more body would exceed `iq_capacity`.
- R7: `reuse_enter` pulses for one cycle in the first cycle of `MODE_REUSE`, and `fe_gate` rises in the following cycle.
- R8: `mispredict` in `MODE_REUSE` returns the mode to `MODE_NORMAL`, drops `fe_gate` and raises `restore_pulse` for one cycle.
- R9: `mispredict` in `MODE_BUFFER` with no abort event raises `revoke_pulse` and returns to `MODE_NORMAL` without recording the loop, so the same loop can be captured again.
- R10: In `MODE_REUSE`, the decode inputs and the abort events have no effect: `fe_gate` stays high.
- R11: After reset the mode is `MODE_NORMAL`, all five outputs are low and the table is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dec_valid | input | 1 | A control transfer is at decode this cycle |
| dec_kind | input | 2 | 00 other, 01 conditional, 10 direct jump, 11 indirect |
| dec_pc | input | PC_W | PC of the transfer |
| dec_target | input | PC_W | Predicted target |
| body_size | input | SZ_W | Loop-body size estimate in queue entries |
| iq_capacity | input | SZ_W | Issue queue capacity in entries |
| mispredict | input | 1 | Branch misprediction notice |
| evt_inner_loop | input | 1 | Inner loop detected |
| evt_loop_exit | input | 1 | Execution left the current loop |
| evt_queue_full | input | 1 | Queue ran out before the loop end |
| buffer_en | output | 1 | Queue should retain entries (`MODE_BUFFER`) |
| fe_gate | output | 1 | Front end may be gated |
| revoke_pulse | output | 1 | One-cycle pulse: buffering revoked |
| restore_pulse | output | 1 | One-cycle pulse: reuse ended |
| reuse_enter | output | 1 | One-cycle pulse on the first cycle of `MODE_REUSE` |

## Verification
A wrong mode shows at the ports on the very next clock edge. Every mode decodes straight to `buffer_en`, `fe_gate` and the pulses, so a missed capture, an early or late commit, or a restore that never comes appears within one cycle of the stimulus that should have caused it. A wrong buffered count shows only when it changes the commit cycle, which may be several iterations later. A wrong table entry shows only when that loop is decoded again, either as a capture that should have been suppressed or a suppression that should not have happened. For that reason the bench replays recorded loops and fills the table past its depth.

// File: rtl/lcc_pkg.sv
package lcc_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_BUFFER = 2'd1,
        MODE_REUSE  = 2'd2
    } mode_e;

    localparam logic [1:0] KIND_OTHER    = 2'b00;
    localparam logic [1:0] KIND_COND     = 2'b01;
    localparam logic [1:0] KIND_JUMP     = 2'b10;
    localparam logic [1:0] KIND_INDIRECT = 2'b11;

endpackage

// File: rtl/lcc_detect.sv
module lcc_detect
    import lcc_pkg::*;
#(
    parameter int PC_W = 32,
    parameter int SZ_W = 8
) (
    input  logic            dec_valid_i,
    input  logic [1:0]      dec_kind_i,
    input  logic [PC_W-1:0] dec_pc_i,
    input  logic [PC_W-1:0] dec_target_i,
    input  logic [SZ_W-1:0] body_size_i,
    input  logic [SZ_W-1:0] iq_capacity_i,
    output logic            xfer_o,
    output logic            cand_o
);

    logic backward;
    logic body_fits;

    always_comb begin
        xfer_o    = dec_valid_i && ((dec_kind_i == KIND_COND) || (dec_kind_i == KIND_JUMP));
        backward  = dec_target_i < dec_pc_i;
        body_fits = (body_size_i != '0) && (body_size_i <= iq_capacity_i);
        cand_o    = xfer_o && backward && body_fits;
    end

endmodule

// File: rtl/lcc_nbl_table.sv
module lcc_nbl_table #(
    parameter int PC_W  = 32,
    parameter int DEPTH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lookup_pc_i,
    output logic            hit_o,
    input  logic            wr_en_i,
    input  logic [PC_W-1:0] wr_pc_i
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [PC_W-1:0]  tag_q   [DEPTH];
    logic [DEPTH-1:0] valid_q;
    logic [DEPTH-1:0] match;
    logic [PTR_W-1:0] ptr_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign match[g] = valid_q[g] && (tag_q[g] == lookup_pc_i);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tag_q[g]   <= '0;
                valid_q[g] <= 1'b0;
            end else if (wr_en_i && (ptr_q == PTR_W'(g))) begin
                tag_q[g]   <= wr_pc_i;
                valid_q[g] <= 1'b1;
            end
        end
    end

    assign hit_o = |match;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (wr_en_i) begin
            ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        end
    end

    // R5
    nbl_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    // R11
    nbl_empty_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (valid_q == '0));

endmodule

// File: rtl/lcc_mode_fsm.sv
module lcc_mode_fsm
    import lcc_pkg::*;
#(
    parameter int PC_W = 32,
    parameter int SZ_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cand_i,
    input  logic            xfer_i,
    input  logic            nbl_hit_i,
    input  logic [PC_W-1:0] dec_pc_i,
    input  logic [SZ_W-1:0] body_size_i,
    input  logic [SZ_W-1:0] iq_capacity_i,
    input  logic            mispredict_i,
    input  logic            evt_inner_i,
    input  logic            evt_exit_i,
    input  logic            evt_full_i,
    output logic            nbl_wr_o,
    output logic [PC_W-1:0] nbl_wr_pc_o,
    output logic            buf_en_o,
    output logic            fe_gate_o,
    output logic            revoke_o,
    output logic            restore_o,
    output logic            reuse_start_o
);

    localparam int CNT_W = SZ_W + 1;

    mode_e            state_q, state_d, prev_q;
    logic [PC_W-1:0]  loop_pc_q;
    logic [SZ_W-1:0]  body_q;
    logic [CNT_W-1:0] used_q;
    logic [CNT_W-1:0] used_next;
    logic             room_left;
    logic             abort_evt;
    logic             capture;
    logic             iter_done;

    always_comb begin
        used_next = used_q + {1'b0, body_q};
        room_left = (used_next + {1'b0, body_q}) <= {1'b0, iq_capacity_i};
        abort_evt = evt_inner_i || evt_exit_i || evt_full_i;
    end

    // next mode
    always_comb begin
        state_d   = state_q;
        capture   = 1'b0;
        iter_done = 1'b0;
        nbl_wr_o  = 1'b0;
        unique case (state_q)
            MODE_NORMAL: begin
                if (cand_i && !nbl_hit_i) begin
                    capture = 1'b1;
                    state_d = MODE_BUFFER;
                end
            end
            MODE_BUFFER: begin
                if (abort_evt) begin
                    nbl_wr_o = 1'b1;
                    state_d  = MODE_NORMAL;
                end else if (mispredict_i) begin
                    state_d = MODE_NORMAL;
                end else if (xfer_i && (dec_pc_i == loop_pc_q)) begin
                    iter_done = 1'b1;
                    if (!room_left) state_d = MODE_REUSE;
                end
            end
            MODE_REUSE: begin
                if (mispredict_i) state_d = MODE_NORMAL;
            end
            default: state_d = MODE_NORMAL;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= MODE_NORMAL;
            prev_q    <= MODE_NORMAL;
            loop_pc_q <= '0;
            body_q    <= '0;
            used_q    <= '0;
        end else begin
            state_q <= state_d;
            prev_q  <= state_q;
            if (capture) begin
                loop_pc_q <= dec_pc_i;
                body_q    <= body_size_i;
                used_q    <= '0;
            end else if (iter_done) begin
                used_q <= used_next;
            end
        end
    end

    // outputs
    always_comb begin
        nbl_wr_pc_o   = loop_pc_q;
        buf_en_o      = (state_q == MODE_BUFFER);
        fe_gate_o     = (state_q == MODE_REUSE) && (prev_q == MODE_REUSE);
        reuse_start_o = (state_q == MODE_REUSE) && (prev_q != MODE_REUSE);
        revoke_o      = (state_q == MODE_NORMAL) && (prev_q == MODE_BUFFER);
        restore_o     = (state_q == MODE_NORMAL) && (prev_q == MODE_REUSE);
    end

    // R2
    gate_buf_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fe_gate_o && buf_en_o));

    // R3
    abort_revokes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_BUFFER && abort_evt) |=> (revoke_o && !buf_en_o));

    // R3
    revoke_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        revoke_o |=> !revoke_o);

    // R4
    nbl_hit_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_NORMAL && cand_i && nbl_hit_i) |=> !buf_en_o);

    // R7
    gate_after_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fe_gate_o) |-> $past(reuse_start_o));

    // R8
    restore_on_mp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_REUSE && mispredict_i) |=> (restore_o && !fe_gate_o));

    // R10
    reuse_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fe_gate_o && !mispredict_i) |=> fe_gate_o);

endmodule

// File: rtl/loop_capture_ctrl.sv
module loop_capture_ctrl
    import lcc_pkg::*;
#(
    parameter int PC_W      = 32,
    parameter int SZ_W      = 8,
    parameter int NBL_DEPTH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dec_valid,
    input  logic [1:0]      dec_kind,
    input  logic [PC_W-1:0] dec_pc,
    input  logic [PC_W-1:0] dec_target,
    input  logic [SZ_W-1:0] body_size,
    input  logic [SZ_W-1:0] iq_capacity,
    input  logic            mispredict,
    input  logic            evt_inner_loop,
    input  logic            evt_loop_exit,
    input  logic            evt_queue_full,
    output logic            buffer_en,
    output logic            fe_gate,
    output logic            revoke_pulse,
    output logic            restore_pulse,
    output logic            reuse_enter
);

    logic            xfer;
    logic            cand;
    logic            nbl_hit;
    logic            nbl_wr;
    logic [PC_W-1:0] nbl_wr_pc;

    lcc_detect #(.PC_W(PC_W), .SZ_W(SZ_W)) u_detect (
        .dec_valid_i   (dec_valid),
        .dec_kind_i    (dec_kind),
        .dec_pc_i      (dec_pc),
        .dec_target_i  (dec_target),
        .body_size_i   (body_size),
        .iq_capacity_i (iq_capacity),
        .xfer_o        (xfer),
        .cand_o        (cand)
    );

    lcc_nbl_table #(.PC_W(PC_W), .DEPTH(NBL_DEPTH)) u_nbl (
        .clk         (clk),
        .rst_n       (rst_n),
        .lookup_pc_i (dec_pc),
        .hit_o       (nbl_hit),
        .wr_en_i     (nbl_wr),
        .wr_pc_i     (nbl_wr_pc)
    );

    lcc_mode_fsm #(.PC_W(PC_W), .SZ_W(SZ_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .cand_i        (cand),
        .xfer_i        (xfer),
        .nbl_hit_i     (nbl_hit),
        .dec_pc_i      (dec_pc),
        .body_size_i   (body_size),
        .iq_capacity_i (iq_capacity),
        .mispredict_i  (mispredict),
        .evt_inner_i   (evt_inner_loop),
        .evt_exit_i    (evt_loop_exit),
        .evt_full_i    (evt_queue_full),
        .nbl_wr_o      (nbl_wr),
        .nbl_wr_pc_o   (nbl_wr_pc),
        .buf_en_o      (buffer_en),
        .fe_gate_o     (fe_gate),
        .revoke_o      (revoke_pulse),
        .restore_o     (restore_pulse),
        .reuse_start_o (reuse_enter)
    );

endmodule

// File: tb/loop_capture_ctrl_bench.sv
module loop_capture_ctrl_bench;

    localparam int CAP = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dec_valid = 1'b0;
    logic [1:0]  dec_kind = 2'b00;
    logic [31:0] dec_pc = '0;
    logic [31:0] dec_target = '0;
    logic [7:0]  body_size = '0;
    logic [7:0]  iq_capacity = 8'(CAP);
    logic        mispredict = 1'b0;
    logic        evt_inner_loop = 1'b0;
    logic        evt_loop_exit = 1'b0;
    logic        evt_queue_full = 1'b0;
    logic        buffer_en, fe_gate, revoke_pulse, restore_pulse, reuse_enter;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // reference model state
    int          m_st = 0;
    int          m_prev = 0;
    logic [31:0] m_tag [8];
    bit          m_val [8];
    int          m_ptr = 0;
    logic [31:0] m_lpc = '0;
    int          m_body = 0;
    int          m_used = 0;

    always #5 clk = ~clk;

    loop_capture_ctrl u_loop_capture_ctrl (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_kind(dec_kind),
        .dec_pc(dec_pc), .dec_target(dec_target), .body_size(body_size),
        .iq_capacity(iq_capacity), .mispredict(mispredict),
        .evt_inner_loop(evt_inner_loop), .evt_loop_exit(evt_loop_exit),
        .evt_queue_full(evt_queue_full), .buffer_en(buffer_en), .fe_gate(fe_gate),
        .revoke_pulse(revoke_pulse), .restore_pulse(restore_pulse), .reuse_enter(reuse_enter)
    );

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic bit m_hit(logic [31:0] pc);
        for (int k = 0; k < 8; k++) if (m_val[k] && m_tag[k] == pc) return 1'b1;
        return 1'b0;
    endfunction

    task automatic model_step();
        bit xfer, cand, abort;
        int nxt;
        xfer  = dec_valid && (dec_kind == 2'b01 || dec_kind == 2'b10);
        cand  = xfer && (dec_target < dec_pc) && body_size != 0 && int'(body_size) <= CAP;
        abort = evt_inner_loop || evt_loop_exit || evt_queue_full;
        nxt = m_st;
        if (m_st == 0) begin
            if (cand && !m_hit(dec_pc)) begin
                nxt = 1; m_lpc = dec_pc; m_body = int'(body_size); m_used = 0;
            end
        end else if (m_st == 1) begin
            if (abort) begin
                m_tag[m_ptr] = m_lpc; m_val[m_ptr] = 1'b1; m_ptr = (m_ptr + 1) % 8; nxt = 0;
            end else if (mispredict) begin
                nxt = 0;
            end else if (xfer && dec_pc == m_lpc) begin
                m_used += m_body;
                if (m_used + m_body > CAP) nxt = 2;
            end
        end else begin
            if (mispredict) nxt = 0;
        end
        m_prev = m_st;
        m_st = nxt;
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        #1;
        check("R2 buffer_en", buffer_en, m_st == 1);
        check("R2/R7 fe_gate", fe_gate, m_st == 2 && m_prev == 2);
        check("R7 reuse_enter", reuse_enter, m_st == 2 && m_prev != 2);
        check("R3 revoke_pulse", revoke_pulse, m_st == 0 && m_prev == 1);
        check("R8 restore_pulse", restore_pulse, m_st == 0 && m_prev == 2);
    endtask

    task automatic idle();
        dec_valid = 0; dec_kind = 2'b00; dec_pc = '0; dec_target = '0; body_size = '0;
        mispredict = 0; evt_inner_loop = 0; evt_loop_exit = 0; evt_queue_full = 0;
    endtask

    task automatic br(logic [1:0] kind, logic [31:0] pc, logic [31:0] tgt, int body);
        idle();
        dec_valid = 1; dec_kind = kind; dec_pc = pc; dec_target = tgt; body_size = 8'(body);
    endtask

    task automatic record_loop(logic [31:0] pc);
        br(2'b01, pc, pc - 32'h20, 4); tick();
        check("R1 capture", buffer_en, 1'b1);
        idle(); evt_loop_exit = 1; tick();
        check("R3 revoke", revoke_pulse, 1'b1);
        idle(); tick();
    endtask

    initial begin
        for (int k = 0; k < 8; k++) begin m_tag[k] = '0; m_val[k] = 0; end
        void'($urandom(32'd20240611));
        idle();
        repeat (3) @(posedge clk);
        #1;
        check("R11 reset buffer_en", buffer_en, 1'b0);
        check("R11 reset fe_gate", fe_gate, 1'b0);
        check("R11 reset pulses", revoke_pulse | restore_pulse | reuse_enter, 1'b0);
        rst_n = 1;
        tick();

        // R1 non-candidates
        br(2'b01, 32'h100, 32'h140, 4); tick(); check("R1 forward", buffer_en, 1'b0);
        br(2'b11, 32'h100, 32'h0C0, 4); tick(); check("R1 indirect", buffer_en, 1'b0);
        br(2'b00, 32'h100, 32'h0C0, 4); tick(); check("R1 other kind", buffer_en, 1'b0);
        br(2'b01, 32'h100, 32'h0C0, 17); tick(); check("R1 oversize", buffer_en, 1'b0);
        idle(); tick();

        // R6 body 5, capacity 16: commit on the third loop-end decode
        br(2'b01, 32'h200, 32'h1F0, 5); tick(); check("R1 capture A", buffer_en, 1'b1);
        br(2'b01, 32'h200, 32'h1F0, 5); tick(); check("R6 iter1 stays", buffer_en, 1'b1);
        idle(); tick();
        br(2'b01, 32'h200, 32'h1F0, 5); tick(); check("R6 iter2 stays", buffer_en, 1'b1);
        br(2'b01, 32'h200, 32'h1F0, 5); tick();
        check("R6 commit", reuse_enter, 1'b1);
        check("R7 gate not yet", fe_gate, 1'b0);
        idle(); tick(); check("R7 gate next", fe_gate, 1'b1);
        check("R7 enter single", reuse_enter, 1'b0);
        // R10 inputs ignored
        br(2'b01, 32'h300, 32'h2F0, 3); evt_loop_exit = 1; evt_inner_loop = 1; evt_queue_full = 1;
        tick(); check("R10 gate holds", fe_gate, 1'b1);
        idle(); mispredict = 1; tick();
        check("R8 restore", restore_pulse, 1'b1);
        check("R8 gate drop", fe_gate, 1'b0);
        idle(); tick(); check("R8 restore single", restore_pulse, 1'b0);

        // R3 and R4
        br(2'b10, 32'h200, 32'h1F0, 5); tick(); check("R1 recapture A", buffer_en, 1'b1);
        idle(); evt_loop_exit = 1; tick(); check("R3 revoke on exit", revoke_pulse, 1'b1);
        idle(); tick(); check("R3 revoke single", revoke_pulse, 1'b0);
        br(2'b01, 32'h200, 32'h1F0, 5); tick(); check("R4 hit blocks", buffer_en, 1'b0);

        // R9 misprediction while buffering is not recorded
        br(2'b01, 32'h300, 32'h2F0, 3); tick(); check("R1 capture B", buffer_en, 1'b1);
        idle(); mispredict = 1; tick(); check("R9 revoke on mp", revoke_pulse, 1'b1);
        br(2'b01, 32'h300, 32'h2F0, 3); tick(); check("R9 B recapturable", buffer_en, 1'b1);
        idle(); evt_queue_full = 1; tick(); check("R3 revoke on full", revoke_pulse, 1'b1);
        idle(); tick();

        // R5 fill the table: A and B recorded, seven more evict A
        for (int n = 0; n < 7; n++) record_loop(32'h400 + 32'(n) * 32'h40);
        br(2'b01, 32'h200, 32'h1F0, 5); tick(); check("R5 A evicted", buffer_en, 1'b1);
        idle(); mispredict = 1; tick();
        br(2'b01, 32'h300, 32'h2F0, 3); tick(); check("R5 B still held", buffer_en, 1'b0);
        idle(); tick();

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            int idx, bsz;
            idle();
            idx = int'($urandom % 5);
            bsz = 1 + int'($urandom % 18);
            dec_valid  = ($urandom % 2) == 0;
            dec_kind   = 2'($urandom % 4);
            dec_pc     = 32'h1000 + 32'(idx) * 32'h40;
            dec_target = (($urandom % 8) == 0) ? dec_pc + 32'h8 : dec_pc - 32'(bsz) * 4;
            body_size  = 8'(bsz);
            mispredict = ($urandom % 40) == 0;
            evt_inner_loop = ($urandom % 90) == 0;
            evt_loop_exit  = ($urandom % 90) == 0;
            evt_queue_full = ($urandom % 90) == 0;
            tick();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule